// File: doc/BRIEF.md
# Interleaved Memory Window Router

The router sits behind one fixed window of host physical address space and steers each memory request to one of several downstream host-bridge ports. A request carries an offset relative to the window. The router adds the window base to form the host physical address. It divides that address by the interleave granularity and takes the quotient modulo the number of configured targets to pick a port. It then forwards the request on a shared downstream channel that is tagged with the port number. The downstream response returns through the router to the requester.

The window base, size, target count, granularity code, a flag that says whether a granularity was given, and a passthrough flag are all static configuration inputs. A per-port presence mask says which ports are attached. When a request cannot be routed, the router answers it locally and does not touch the downstream side. A read that cannot be routed completes with an error and zero data. A write that cannot be routed is dropped but completes without an error. Only one transaction is in flight at a time.

Top module: `mem_window_router`

## Requirements
- R1: A forwarded request carries `dn_hpa` equal to `cfg_base + req_ofs`, computed modulo 2^HPA_W.
- R2: With passthrough off, `dn_port` equals (`dn_hpa` >> (8 + g)) mod `cfg_tgt_cnt`, where g is the effective granularity code. Legal counts are 1, 2, 4 and 8, plus 3, 6 and 12 when the three-way option is built in and the count does not exceed MAX_TGT.
- R3: When `cfg_gran_set` is 0, the effective granularity code is 0 (256-byte interleave) whatever `cfg_gran_enc` holds.
- R4: When `cfg_passthru` is 1, every forwarded request goes to port 0.
- R5: `cfg_err` is 1 exactly when any of these holds: `cfg_size` is zero; `cfg_size` is not a multiple of 2^28 bytes; `cfg_gran_set` is 1 with `cfg_gran_enc` above 6; or the count is not legal. While `cfg_err` is 1, no request is routable.
- R6: A read that cannot be routed is not forwarded and completes with `rsp_err`=1 and `rsp_rdata`=0.
- R7: A write that cannot be routed is not forwarded and completes with `rsp_err`=0 and `rsp_rdata`=0.
- R8: A request cannot be routed when any of these holds: `req_ofs` >= `cfg_size`; `req_len` is outside 1..8; or the selected port's bit in `tgt_present` (bit i for port i) is 0.
- R9: Byte counts from 1 to 8 at any byte alignment are forwarded with `dn_len`, `dn_write` and `dn_wdata` unchanged. Byte k of the access sits in `wdata[8k+7:8k]` (little-endian lanes).
- R10: `req_ready` is 0 from the accepting edge until the response handshake, so only one transaction is outstanding. `dn_valid` and `dn_port` hold steady until `dn_ready`.
- R11: For a forwarded read, `rsp_rdata` and `rsp_err` equal the downstream response. For a forwarded write, `rsp_err` equals the downstream error and `rsp_rdata` is 0.
- R12: After reset, `req_ready`=1, `dn_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | HPA_W | Window base host address |
| cfg_size | input | HPA_W | Window size in bytes |
| cfg_tgt_cnt | input | 4 | Number of interleave targets |
| cfg_gran_set | input | 1 | Granularity code supplied |
| cfg_gran_enc | input | 3 | Granularity code (256 << code bytes) |
| cfg_passthru | input | 1 | Send everything to port 0 |
| tgt_present | input | MAX_TGT | Per-port attached mask |
| cfg_err | output | 1 | Configuration illegal |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ofs | input | OFS_W | Window-relative byte offset |
| req_len | input | 4 | Byte count |
| req_wdata | input | 64 | Write data, little-endian lanes |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request taken |
| dn_port | output | PORT_W | Selected target port |
| dn_hpa | output | HPA_W | Host physical address |
| dn_write | output | 1 | Downstream write flag |
| dn_len | output | 4 | Downstream byte count |
| dn_wdata | output | 64 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_err | input | 1 | Downstream response error |
| dn_rsp_rdata | input | 64 | Downstream read data |
| rsp_valid | output | 1 | Upstream response valid |
| rsp_ready | input | 1 | Upstream response taken |
| rsp_err | output | 1 | Upstream response error |
| rsp_rdata | output | 64 | Upstream read data |

## Verification
The bench uses the default parameters: MAX_TGT of 12 with the three-way option enabled, a 48-bit host address and a 34-bit offset. This brings every legal count within reach, including 3, 6 and 12, whose modulo path differs from the power-of-two masks. It also allows windows of several GiB, so the out-of-range check at the exact window end can be tested. Base addresses are chosen so that the base itself changes the quotient. Every granularity code from 0 to 6 is applied, along with codes that leave the count or size illegal.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  localparam int CNT_W        = 4;
  localparam int GRAN_W       = 3;
  localparam int LEN_W        = 4;
  localparam int GRAN_LOG2_LO = 8;   // 256-byte minimum granule
  localparam int SIZE_LOG2    = 28;  // window size unit
  localparam int MAX_GRAN_ENC = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } txn_state_e;

  // Remainder of a 64-bit value by three: 4 == 1 (mod 3), so sum 2-bit digits.
  function automatic logic [1:0] mod3_fold(input logic [63:0] v);
    logic [2:0] acc;
    acc = 3'd0;
    for (int i = 0; i < 32; i++) begin
      acc = acc + {1'b0, v[2*i +: 2]};
      if (acc >= 3'd3) acc = acc - 3'd3;
    end
    return acc[1:0];
  endfunction

endpackage

// File: rtl/mwr_cfg_check.sv
module mwr_cfg_check
  import mwr_pkg::*;
#(
  parameter int HPA_W   = 48,
  parameter int MAX_TGT = 12,
  parameter bit EN_3X   = 1'b1
) (
  input  logic [HPA_W-1:0]  cfg_size,
  input  logic [CNT_W-1:0]  cfg_tgt_cnt,
  input  logic              cfg_gran_set,
  input  logic [GRAN_W-1:0] cfg_gran_enc,
  output logic [GRAN_W-1:0] gran_eff,
  output logic              cfg_ok
);

  logic size_ok;
  logic gran_ok;
  logic cnt_shape_ok;
  logic cnt_fits;

  assign size_ok  = (cfg_size[SIZE_LOG2-1:0] == '0) && (cfg_size != '0);
  assign gran_ok  = !cfg_gran_set || (cfg_gran_enc <= GRAN_W'(MAX_GRAN_ENC));
  assign gran_eff = cfg_gran_set ? cfg_gran_enc : '0;
  assign cnt_fits = (32'(cfg_tgt_cnt) <= MAX_TGT);

  generate
    if (EN_3X) begin : g_cnt_3x
      always_comb begin
        case (cfg_tgt_cnt)
          4'd1, 4'd2, 4'd4, 4'd8, 4'd3, 4'd6, 4'd12: cnt_shape_ok = 1'b1;
          default:                                   cnt_shape_ok = 1'b0;
        endcase
      end
    end else begin : g_cnt_pow2
      always_comb begin
        case (cfg_tgt_cnt)
          4'd1, 4'd2, 4'd4, 4'd8: cnt_shape_ok = 1'b1;
          default:                cnt_shape_ok = 1'b0;
        endcase
      end
    end
  endgenerate

  assign cfg_ok = size_ok && gran_ok && cnt_shape_ok && cnt_fits;

endmodule

// File: rtl/mwr_port_select.sv
module mwr_port_select
  import mwr_pkg::*;
#(
  parameter int HPA_W  = 48,
  parameter int PORT_W = 4,
  parameter bit EN_3X  = 1'b1
) (
  input  logic [HPA_W-1:0]  hpa,
  input  logic [GRAN_W-1:0] gran_eff,
  input  logic [CNT_W-1:0]  tgt_cnt,
  output logic [PORT_W-1:0] port_idx
);

  localparam int IDX_W = 4;

  logic [3:0]       shamt;
  logic [HPA_W-1:0] quo;
  logic [1:0]       rem3 [3];
  logic [IDX_W-1:0] idx_wide;

  assign shamt = 4'(GRAN_LOG2_LO) + 4'(gran_eff);
  assign quo   = hpa >> shamt;

  // count = 3 * 2^k: remainder is ((quo >> k) mod 3) placed above the low k bits
  generate
    for (genvar k = 0; k < 3; k++) begin : g_rem
      if (EN_3X) begin : g_on
        assign rem3[k] = mod3_fold(64'(quo >> k));
      end else begin : g_off
        assign rem3[k] = 2'd0;
      end
    end
  endgenerate

  always_comb begin
    case (tgt_cnt)
      4'd2:    idx_wide = {3'b000, quo[0]};
      4'd4:    idx_wide = {2'b00, quo[1:0]};
      4'd8:    idx_wide = {1'b0, quo[2:0]};
      4'd3:    idx_wide = {2'b00, rem3[0]};
      4'd6:    idx_wide = {1'b0, rem3[1], quo[0]};
      4'd12:   idx_wide = {rem3[2], quo[1:0]};
      default: idx_wide = '0;
    endcase
  end

  assign port_idx = idx_wide[PORT_W-1:0];

endmodule

// File: rtl/mwr_txn_ctrl.sv
module mwr_txn_ctrl
  import mwr_pkg::*;
#(
  parameter int HPA_W  = 48,
  parameter int DATA_W = 64,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              route_ok,
  input  logic [PORT_W-1:0] sel_port,
  input  logic [HPA_W-1:0]  sel_hpa,
  output logic              req_ready,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [PORT_W-1:0] dn_port,
  output logic [HPA_W-1:0]  dn_hpa,
  output logic              dn_write,
  output logic [LEN_W-1:0]  dn_len,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic              dn_rsp_err,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  txn_state_e        state_q, state_d;
  logic [PORT_W-1:0] port_q;
  logic [HPA_W-1:0]  hpa_q;
  logic              write_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q, err_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              accept;
  logic              rsp_load;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign rsp_load = accept || ((state_q == ST_WAIT) && dn_rsp_valid);

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    rdata_d = rdata_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          // a request that cannot be routed is answered locally
          state_d = route_ok ? ST_FWD : ST_RESP;
          err_d   = !req_write;
          rdata_d = '0;
        end
      end
      ST_FWD: begin
        if (dn_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (dn_rsp_valid) begin
          state_d = ST_RESP;
          err_d   = dn_rsp_err;
          rdata_d = write_q ? '0 : dn_rsp_rdata;
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      hpa_q   <= '0;
      write_q <= 1'b0;
      len_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      port_q  <= sel_port;
      hpa_q   <= sel_hpa;
      write_q <= req_write;
      len_q   <= req_len;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else if (rsp_load) begin
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign dn_valid  = (state_q == ST_FWD);
  assign rsp_valid = (state_q == ST_RESP);
  assign dn_port   = port_q;
  assign dn_hpa    = hpa_q;
  assign dn_write  = write_q;
  assign dn_len    = len_q;
  assign dn_wdata  = wdata_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/mem_window_router.sv
module mem_window_router
  import mwr_pkg::*;
#(
  parameter int HPA_W   = 48,
  parameter int OFS_W   = 34,
  parameter int DATA_W  = 64,
  parameter int MAX_TGT = 12,
  parameter bit EN_3X   = 1'b1,
  localparam int PORT_W = (MAX_TGT > 1) ? $clog2(MAX_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HPA_W-1:0]   cfg_base,
  input  logic [HPA_W-1:0]   cfg_size,
  input  logic [CNT_W-1:0]   cfg_tgt_cnt,
  input  logic               cfg_gran_set,
  input  logic [GRAN_W-1:0]  cfg_gran_enc,
  input  logic               cfg_passthru,
  input  logic [MAX_TGT-1:0] tgt_present,
  output logic               cfg_err,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [OFS_W-1:0]   req_ofs,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [PORT_W-1:0]  dn_port,
  output logic [HPA_W-1:0]   dn_hpa,
  output logic               dn_write,
  output logic [LEN_W-1:0]   dn_len,
  output logic [DATA_W-1:0]  dn_wdata,
  input  logic               dn_rsp_valid,
  input  logic               dn_rsp_err,
  input  logic [DATA_W-1:0]  dn_rsp_rdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata
);

  localparam int MAX_LEN = DATA_W / 8;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [GRAN_W-1:0] gran_eff;
  logic              cfg_ok;
  logic [HPA_W-1:0]  hpa;
  logic [PORT_W-1:0] ilv_port;
  logic [PORT_W-1:0] sel_port;
  logic              in_window;
  logic              len_ok;
  logic              port_here;
  logic              route_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  mwr_cfg_check #(
    .HPA_W  (HPA_W),
    .MAX_TGT(MAX_TGT),
    .EN_3X  (EN_3X)
  ) u_cfg (
    .cfg_size    (cfg_size),
    .cfg_tgt_cnt (cfg_tgt_cnt),
    .cfg_gran_set(cfg_gran_set),
    .cfg_gran_enc(cfg_gran_enc),
    .gran_eff    (gran_eff),
    .cfg_ok      (cfg_ok)
  );

  assign hpa = cfg_base + HPA_W'(req_ofs);

  mwr_port_select #(
    .HPA_W (HPA_W),
    .PORT_W(PORT_W),
    .EN_3X (EN_3X)
  ) u_sel (
    .hpa     (hpa),
    .gran_eff(gran_eff),
    .tgt_cnt (cfg_tgt_cnt),
    .port_idx(ilv_port)
  );

  assign sel_port  = cfg_passthru ? '0 : ilv_port;
  assign in_window = (HPA_W'(req_ofs) < cfg_size);
  assign len_ok    = (req_len != '0) && (32'(req_len) <= MAX_LEN);
  assign port_here = (32'(sel_port) < MAX_TGT) ? tgt_present[sel_port] : 1'b0;
  assign route_ok  = cfg_ok && in_window && len_ok && port_here;
  assign cfg_err   = !cfg_ok;

  mwr_txn_ctrl #(
    .HPA_W (HPA_W),
    .DATA_W(DATA_W),
    .PORT_W(PORT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_len     (req_len),
    .req_wdata   (req_wdata),
    .route_ok    (route_ok),
    .sel_port    (sel_port),
    .sel_hpa     (hpa),
    .req_ready   (req_ready),
    .dn_valid    (dn_valid),
    .dn_ready    (dn_ready),
    .dn_port     (dn_port),
    .dn_hpa      (dn_hpa),
    .dn_write    (dn_write),
    .dn_len      (dn_len),
    .dn_wdata    (dn_wdata),
    .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_err  (dn_rsp_err),
    .dn_rsp_rdata(dn_rsp_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata)
  );

endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int HPA_W  = 48,
  parameter int OFS_W  = 34,
  parameter int DATA_W = 64,
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HPA_W-1:0]  cfg_base,
  input logic              cfg_passthru,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [OFS_W-1:0]  req_ofs,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [PORT_W-1:0] dn_port,
  input logic [HPA_W-1:0]  dn_hpa,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata
);

  logic [OFS_W-1:0] ofs_cap;
  logic             wr_cap;
  logic             fwd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_cap  <= '0;
      wr_cap   <= 1'b0;
      fwd_seen <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        ofs_cap  <= req_ofs;
        wr_cap   <= req_write;
        fwd_seen <= 1'b0;
      end else if (dn_valid && dn_ready) begin
        fwd_seen <= 1'b1;
      end
    end
  end

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid || rsp_valid) |-> !req_ready);

  a_r10_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_port) && $stable(dn_hpa)));

  a_r1_hpa_sum: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_hpa == cfg_base + HPA_W'(ofs_cap)));

  a_r4_passthru_port0: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && cfg_passthru) |-> (dn_port == '0));

  a_r6_unrouted_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fwd_seen && !wr_cap) |-> (rsp_err && (rsp_rdata == '0)));

  a_r7_unrouted_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fwd_seen && wr_cap) |-> !rsp_err);

endmodule

bind mem_window_router mwr_checker #(
  .HPA_W (HPA_W),
  .OFS_W (OFS_W),
  .DATA_W(DATA_W),
  .PORT_W(PORT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .cfg_base    (cfg_base),
  .cfg_passthru(cfg_passthru),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_ofs     (req_ofs),
  .dn_valid    (dn_valid),
  .dn_ready    (dn_ready),
  .dn_port     (dn_port),
  .dn_hpa      (dn_hpa),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata)
);

// File: tb/sim_mem_window_router.sv
`timescale 1ns/1ps
module sim_mem_window_router;

  localparam int HPA_W = 48, OFS_W = 34, DATA_W = 64, MAX_TGT = 12, PORT_W = 4;

  logic clk, rst_n;
  logic [HPA_W-1:0] cfg_base, cfg_size;
  logic [3:0] cfg_tgt_cnt;
  logic cfg_gran_set, cfg_passthru, cfg_err;
  logic [2:0] cfg_gran_enc;
  logic [MAX_TGT-1:0] tgt_present;
  logic req_valid, req_ready, req_write;
  logic [OFS_W-1:0] req_ofs;
  logic [3:0] req_len;
  logic [DATA_W-1:0] req_wdata;
  logic dn_valid, dn_ready, dn_write;
  logic [PORT_W-1:0] dn_port;
  logic [HPA_W-1:0] dn_hpa;
  logic [3:0] dn_len;
  logic [DATA_W-1:0] dn_wdata, dn_rsp_rdata, rsp_rdata;
  logic dn_rsp_valid, dn_rsp_err, rsp_valid, rsp_ready, rsp_err;

  mem_window_router u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    bit fwd; bit wr; logic [3:0] port; logic [HPA_W-1:0] hpa;
    logic [3:0] len; logic [DATA_W-1:0] wdata; bit err_inj;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_checks = 0, n_errors = 0, done_cnt = 0;
  bit dn_err_inj = 1'b0;
  logic [HPA_W-1:0] cur_hpa;
  logic [3:0] cur_port;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] dn_data(logic [HPA_W-1:0] h, logic [3:0] p);
    return {12'hD0D, p, h};
  endfunction

  function automatic bit model_cfg_ok();
    bit c;
    c = (cfg_tgt_cnt inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});
    return (cfg_size % (48'd1 << 28) == 0) && (cfg_size != 0) &&
           (!cfg_gran_set || cfg_gran_enc <= 3'd6) && c;
  endfunction

  task automatic set_cfg(logic [HPA_W-1:0] b, logic [HPA_W-1:0] s, int cnt,
                         bit gs, int ge, bit pt, string tag);
    @(negedge clk);
    cfg_base = b; cfg_size = s; cfg_tgt_cnt = 4'(cnt);
    cfg_gran_set = gs; cfg_gran_enc = 3'(ge); cfg_passthru = pt;
    @(negedge clk);
    chk(tag, "cfg_err", 64'(cfg_err), 64'(!model_cfg_ok()));
  endtask

  task automatic send(bit wr, logic [OFS_W-1:0] ofs, int len,
                      logic [DATA_W-1:0] wd, string tag);
    exp_t e;
    int g, target;
    logic [HPA_W-1:0] q;
    e.wr = wr; e.len = 4'(len); e.wdata = wd; e.err_inj = dn_err_inj;
    e.hpa = cfg_base + HPA_W'(ofs);
    g = cfg_gran_set ? int'(cfg_gran_enc) : 0;
    q = e.hpa >> (8 + g);
    e.port = 4'd0;
    if (model_cfg_ok() && !cfg_passthru) e.port = 4'(q % HPA_W'(cfg_tgt_cnt));
    e.fwd = model_cfg_ok() && (HPA_W'(ofs) < cfg_size) && len >= 1 && len <= 8
            && tgt_present[e.port];
    exp_q.push_back(e); tag_q.push_back(tag);
    target = done_cnt + 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_ofs = ofs; req_len = 4'(len); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt < target) @(negedge clk);
  endtask

  // scoreboard monitor and downstream responder
  always @(negedge clk) begin
    if (dn_rsp_valid) dn_rsp_valid = 1'b0;
    if (dn_ready) begin
      dn_ready = 1'b0;
      dn_rsp_valid = 1'b1;
      dn_rsp_rdata = dn_data(cur_hpa, cur_port);
      dn_rsp_err = (exp_q.size() != 0) ? exp_q[0].err_inj : 1'b0;
    end else if (dn_valid) begin
      if (exp_q.size() == 0 || !exp_q[0].fwd) begin
        chk((tag_q.size() != 0) ? tag_q[0] : "R6/R7", "unexpected forward", 64'd1, 64'd0);
      end else begin
        chk(tag_q[0], "dn_port", 64'(dn_port), 64'(exp_q[0].port));
        chk(tag_q[0], "dn_hpa", 64'(dn_hpa), 64'(exp_q[0].hpa));
        chk(tag_q[0], "R9 dn_len/write", {59'd0, dn_write, dn_len}, {59'd0, exp_q[0].wr, exp_q[0].len});
        if (exp_q[0].wr) chk(tag_q[0], "R9 dn_wdata", dn_wdata, exp_q[0].wdata);
        chk("R10", "req_ready while busy", 64'(req_ready), 64'd0);
      end
      cur_hpa = dn_hpa; cur_port = dn_port;
      dn_ready = 1'b1;
    end
    if (rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R10", "spurious response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        logic [63:0] er;
        bit ee;
        e = exp_q.pop_front();
        if (e.fwd) begin
          ee = e.err_inj;
          er = e.wr ? 64'd0 : dn_data(e.hpa, e.port);
        end else begin
          ee = !e.wr;
          er = 64'd0;
        end
        chk(tag_q[0], "rsp_err", 64'(rsp_err), 64'(ee));
        chk(tag_q[0], "rsp_rdata", rsp_rdata, er);
        void'(tag_q.pop_front());
      end
      done_cnt++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_ofs = '0; req_len = '0;
    req_wdata = '0; dn_ready = 1'b0; dn_rsp_valid = 1'b0; dn_rsp_err = 1'b0;
    dn_rsp_rdata = '0; rsp_ready = 1'b1; tgt_present = '1;
    cfg_base = 48'h10_0000_0000; cfg_size = 48'h4000_0000; cfg_tgt_cnt = 4'd4;
    cfg_gran_set = 1'b1; cfg_gran_enc = 3'd0; cfg_passthru = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "req_ready", 64'(req_ready), 64'd1);
    chk("R12", "dn_valid", 64'(dn_valid), 64'd0);
    chk("R12", "rsp_valid", 64'(rsp_valid), 64'd0);

    // R1 R2: four-way, 256-byte granule
    set_cfg(48'h10_0000_0000, 48'h4000_0000, 4, 1, 0, 0, "R5");
    for (int i = 0; i < 6; i++) send(0, 34'(i * 256), 8, '0, "R1/R2 cnt4");
    // R2: three-way and other counts over all codes 0..6
    set_cfg(48'h10_0000_0300, 48'h1_0000_0000, 3, 1, 2, 0, "R5");
    for (int i = 0; i < 5; i++) send(0, 34'(i * 1024 + 5), 4, '0, "R2 cnt3");
    set_cfg(48'h3_0000_0000, 48'h2000_0000, 6, 1, 1, 0, "R5");
    for (int i = 0; i < 7; i++) send(0, 34'(i * 512), 2, '0, "R2 cnt6");
    set_cfg(48'h5_1230_0000, 48'h3_0000_0000, 12, 1, 6, 0, "R5");
    for (int i = 0; i < 13; i++) send(0, 34'(i * 16384), 1, '0, "R2 cnt12");
    set_cfg(48'h0, 48'h1000_0000, 8, 1, 3, 0, "R5");
    for (int i = 0; i < 9; i++) send(1, 34'(i * 2048 + 1), 8, 64'(i), "R2 cnt8");
    set_cfg(48'h0, 48'h1000_0000, 2, 1, 4, 0, "R5");
    send(0, 34'h1000, 8, '0, "R2 cnt2");
    set_cfg(48'h0, 48'h1000_0000, 1, 1, 5, 0, "R5");
    send(0, 34'h8000, 8, '0, "R2 cnt1");
    // R3: granularity not set -> 256 bytes despite code 5
    set_cfg(48'h0, 48'h1000_0000, 4, 0, 5, 0, "R3");
    for (int i = 0; i < 4; i++) send(0, 34'(i * 256), 8, '0, "R3 default gran");
    // R4: passthrough
    set_cfg(48'h0, 48'h1000_0000, 4, 1, 0, 1, "R4");
    for (int i = 0; i < 4; i++) send(0, 34'(i * 256), 8, '0, "R4 passthru");
    // R9: byte counts and alignment
    set_cfg(48'h7_0000_0000, 48'h1000_0000, 8, 1, 0, 0, "R9");
    for (int l = 1; l <= 8; l++) send(1, 34'(l * 257 + 3), l, 64'h8877_6655_4433_2211, "R9 len");
    // R8: window end, bad lengths, missing port
    send(0, 34'h0FFF_FFFF, 1, '0, "R8 last byte");
    send(0, 34'h1000_0000, 1, '0, "R8/R6 past end read");
    send(1, 34'h1000_0000, 1, 64'h1, "R8/R7 past end write");
    send(0, 34'h10, 0, '0, "R8 len0");
    send(1, 34'h10, 9, '0, "R8 len9");
    tgt_present = 12'hFFB;
    send(0, 34'h200, 8, '0, "R8/R6 absent port read");
    send(1, 34'h200, 8, 64'h5, "R8/R7 absent port write");
    send(0, 34'h300, 8, '0, "R8 present port");
    tgt_present = '1;
    // R11: downstream error passes through
    dn_err_inj = 1'b1;
    send(0, 34'h40, 8, '0, "R11 read err");
    send(1, 34'h40, 8, 64'h9, "R11 write err");
    dn_err_inj = 1'b0;
    // R5: illegal configurations block routing
    set_cfg(48'h0, 48'h1000_1000, 4, 1, 0, 0, "R5 size");
    send(0, 34'h0, 8, '0, "R5/R6 size read");
    set_cfg(48'h0, 48'h1000_0000, 4, 1, 7, 0, "R5 gran7");
    send(1, 34'h0, 8, 64'h3, "R5/R7 gran write");
    set_cfg(48'h0, 48'h1000_0000, 5, 1, 0, 0, "R5 cnt5");
    send(0, 34'h0, 8, '0, "R5 cnt5 read");
    set_cfg(48'h0, 48'h1000_0000, 0, 1, 0, 0, "R5 cnt0");
    set_cfg(48'h0, 48'h0, 4, 1, 0, 0, "R5 size0");
    send(0, 34'h0, 8, '0, "R5 size0 read");
    repeat (4) @(negedge clk);
    summary();
  end

endmodule